// File: doc/BRIEF.md
# Block-Mode DMA Transfer Sequencer

This block moves data from one memory region to another in fixed-size blocks. Software programs a source start address, a destination start address, a block size and a number of blocks through a small register write port. It then sets the enable bit. Each pulse on the request input moves one whole block, one unit at a time. A unit is a byte or a 16-bit word. Each unit is a read cycle from the source followed by a write cycle to the destination. Both cycles go over a simple bus that has a ready handshake.

The block size sits in the upper byte of a 16-bit size register. The lower byte counts the units left in the current block. When that count runs out it is reloaded from the upper byte. A separate block counter counts down completed blocks. When it reaches zero, the sequencer raises the done flag and clears its own enable bit.

One side, source or destination, is named the block area. That side's address returns to its start value after every block. The other side keeps advancing from block to block.

Top module: `blkdma_seq`

## Requirements
- R1: Writing select 0 loads the source start address and select 1 loads the destination start address. The first read of a block uses the source address and the first write uses the destination address.
- R2: Select 2 loads the size register: bits 15:8 are the block size and bits 7:0 are the units left. One request with enable set makes the block perform that many read-then-write unit pairs and then go idle.
- R3: Select 4 is the control register. Bit 0 is enable, bit 1 is word units, bit 2 names the destination as block area (0 names the source), bits 4:3 are the source address mode and bits 6:5 are the destination address mode. Mode 0 holds the address, 1 adds the step and 2 subtracts it after each unit. The step is 1 for bytes and 2 for words.
- R4: At the end of each block, the block-area side's address returns to its start value. The other side continues from where it stopped.
- R5: Select 3 loads the block count. When the units-left count reaches zero it is reloaded from the block size and the block count drops by one. When the block count reaches zero, done goes to 1 and enable goes to 0. Writing control clears done.
- R6: A request is ignored while a block is in progress and while enable is 0. An ignored request produces no bus cycles.
- R7: bus_rd and bus_wr are never high together. A strobe stays high, with its address and write data held, until a cycle in which bus_ready is high.
- R8: Each write carries the data returned by the preceding read. In byte mode the upper byte of the write data is zero.
- R9: After reset there are no strobes, and busy, enable and done are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 src, 1 dst, 2 size, 3 blocks, 4 control) |
| cfg_wdata | input | 24 | Register write data |
| req | input | 1 | Transfer request, one block per accepted pulse |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_word | output | 1 | 1 for word units, 0 for byte units |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken when bus_ready is high during a read |
| bus_ready | input | 1 | Completes the current bus cycle |
| busy | output | 1 | A block is in progress |
| enable | output | 1 | Current enable bit |
| done | output | 1 | Final block finished |

## Verification
A wrong address-unit state appears on bus_addr at the next unit's read or write, one or two bus cycles after the error. A missed block-area restore appears only at the first unit of the next block. A wrong units-left count shows up as a block that ends early or late: either an extra bus cycle with no expected item, or a bus that goes quiet while items remain queued. A wrong block counter is seen only at the last block, as done rising at the wrong time or not at all, and as enable left set. A wrong data latch is seen at the write that follows the read.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_e;

   localparam logic [2:0] SEL_SRC    = 3'd0;
   localparam logic [2:0] SEL_DST    = 3'd1;
   localparam logic [2:0] SEL_SIZE   = 3'd2;
   localparam logic [2:0] SEL_BLOCKS = 3'd3;
   localparam logic [2:0] SEL_CTRL   = 3'd4;

   localparam int CTRL_EN       = 0;
   localparam int CTRL_WORD     = 1;
   localparam int CTRL_AREA_DST = 2;
   localparam int CTRL_SMODE_LO = 3;
   localparam int CTRL_DMODE_LO = 5;
endpackage

// File: rtl/blkdma_addr_unit.sv
module blkdma_addr_unit
   import blkdma_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              restore,
   input  step_mode_e        mode,
   input  logic              word,
   output logic [ADDR_W-1:0] cur
);
   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] stride;
   logic [ADDR_W-1:0] next_addr;

   initial begin
      assert (ADDR_W >= 8 && ADDR_W <= 32)
         else $fatal(1, "blkdma_addr_unit: ADDR_W out of range");
   end

   assign stride = word ? ADDR_W'(2) : ADDR_W'(1);

   always_comb begin
      case (mode)
         STEP_UP:   next_addr = cur_q + stride;
         STEP_DOWN: next_addr = cur_q - stride;
         default:   next_addr = cur_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         cur_q   <= '0;
      end else if (load) begin
         start_q <= load_val;
         cur_q   <= load_val;
      end else if (restore) begin
         cur_q <= start_q;
      end else if (step) begin
         cur_q <= next_addr;
      end
   end

   assign cur = cur_q;

   p_hold_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == STEP_HOLD && !load && !restore) |=> $stable(cur_q));

   p_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (restore && !load) |=> (cur_q == $past(start_q)));
endmodule

// File: rtl/blkdma_counters.sv
module blkdma_counters #(
   parameter int SIZE_W = 8,
   parameter int BLK_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_size,
   input  logic [2*SIZE_W-1:0] size_val,
   input  logic                ld_blk,
   input  logic [BLK_W-1:0]    blk_val,
   input  logic                unit_done,
   output logic                block_end,
   output logic                last_block
);
   localparam logic [SIZE_W-1:0] LEFT_ONE = SIZE_W'(1);
   localparam logic [BLK_W-1:0]  BLK_ONE  = BLK_W'(1);

   logic [SIZE_W-1:0] size_q;
   logic [SIZE_W-1:0] left_q;
   logic [BLK_W-1:0]  blk_q;

   initial begin
      assert (SIZE_W >= 2 && SIZE_W <= 16)
         else $fatal(1, "blkdma_counters: SIZE_W out of range");
      assert (BLK_W >= 2 && BLK_W <= 32)
         else $fatal(1, "blkdma_counters: BLK_W out of range");
   end

   assign block_end  = unit_done && (left_q == LEFT_ONE);
   assign last_block = (blk_q == BLK_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         left_q <= '0;
      end else if (ld_size) begin
         size_q <= size_val[2*SIZE_W-1:SIZE_W];
         left_q <= size_val[SIZE_W-1:0];
      end else if (unit_done) begin
         if (left_q == LEFT_ONE) left_q <= size_q;
         else                    left_q <= left_q - LEFT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         blk_q <= '0;
      else if (ld_blk)    blk_q <= blk_val;
      else if (block_end) blk_q <= blk_q - BLK_ONE;
   end

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (block_end && !ld_size) |=> (left_q == $past(size_q)));

   p_blk_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (block_end && !ld_blk) |=> (blk_q == $past(blk_q) - BLK_ONE));

   p_size_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_size |=> $stable(size_q));
endmodule

// File: rtl/blkdma_fsm.sv
module blkdma_fsm
   import blkdma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       bus_ready,
   input  logic       block_end,
   input  logic       last_block,
   output seq_state_e state,
   output logic       latch_rd,
   output logic       unit_done,
   output logic       finish
);
   seq_state_e state_q;
   seq_state_e state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (go) state_d = ST_READ;
         ST_READ:  if (bus_ready) state_d = ST_WRITE;
         ST_WRITE: if (bus_ready) state_d = block_end ? ST_IDLE : ST_READ;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state     = state_q;
   assign latch_rd  = (state_q == ST_READ) && bus_ready;
   assign unit_done = (state_q == ST_WRITE) && bus_ready;
   assign finish    = unit_done && block_end && last_block;

   p_read_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && !bus_ready) |=> (state_q == ST_READ));

   p_write_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE && !bus_ready) |=> (state_q == ST_WRITE));

   p_block_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE && bus_ready && block_end) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
   import blkdma_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int SIZE_W = 8,
   parameter int BLK_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_word,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   output logic              busy,
   output logic              enable,
   output logic              done
);
   localparam int LANE_W = DATA_W / 2;

   initial begin
      assert (DATA_W == 16 || DATA_W == 32)
         else $fatal(1, "blkdma_seq: DATA_W must be 16 or 32");
      assert (ADDR_W >= 2*SIZE_W && ADDR_W >= BLK_W && ADDR_W >= 7)
         else $fatal(1, "blkdma_seq: cfg_wdata too narrow for the count fields");
   end

   logic              en_q, word_q, area_dst_q, done_q;
   step_mode_e        smode_q, dmode_q;
   logic [DATA_W-1:0] data_q;
   logic              ctrl_wr;

   seq_state_e state;
   logic       latch_rd, unit_done, finish;
   logic       block_end, last_block;
   logic       go;

   logic [ADDR_W-1:0] side_addr [2];

   assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
   assign go      = en_q && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         word_q     <= 1'b0;
         area_dst_q <= 1'b0;
         smode_q    <= STEP_HOLD;
         dmode_q    <= STEP_HOLD;
         done_q     <= 1'b0;
      end else if (ctrl_wr) begin
         en_q       <= cfg_wdata[CTRL_EN];
         word_q     <= cfg_wdata[CTRL_WORD];
         area_dst_q <= cfg_wdata[CTRL_AREA_DST];
         smode_q    <= step_mode_e'(cfg_wdata[CTRL_SMODE_LO +: 2]);
         dmode_q    <= step_mode_e'(cfg_wdata[CTRL_DMODE_LO +: 2]);
         done_q     <= 1'b0;
      end else if (finish) begin
         en_q   <= 1'b0;
         done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (latch_rd) data_q <= word_q ? bus_rdata
                                          : {{(DATA_W-LANE_W){1'b0}}, bus_rdata[LANE_W-1:0]};
   end

   for (genvar s = 0; s < 2; s++) begin : g_side
      step_mode_e side_mode;
      logic       side_load;
      logic       side_restore;

      assign side_mode    = (s == 0) ? smode_q : dmode_q;
      assign side_load    = cfg_we && (cfg_sel == ((s == 0) ? SEL_SRC : SEL_DST));
      assign side_restore = block_end && (area_dst_q == 1'(s));

      blkdma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (side_load),
         .load_val (cfg_wdata),
         .step     (unit_done),
         .restore  (side_restore),
         .mode     (side_mode),
         .word     (word_q),
         .cur      (side_addr[s])
      );
   end

   blkdma_counters #(.SIZE_W(SIZE_W), .BLK_W(BLK_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_size    (cfg_we && cfg_sel == SEL_SIZE),
      .size_val   (cfg_wdata[2*SIZE_W-1:0]),
      .ld_blk     (cfg_we && cfg_sel == SEL_BLOCKS),
      .blk_val    (cfg_wdata[BLK_W-1:0]),
      .unit_done  (unit_done),
      .block_end  (block_end),
      .last_block (last_block)
   );

   blkdma_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .bus_ready  (bus_ready),
      .block_end  (block_end),
      .last_block (last_block),
      .state      (state),
      .latch_rd   (latch_rd),
      .unit_done  (unit_done),
      .finish     (finish)
   );

   assign bus_rd    = (state == ST_READ);
   assign bus_wr    = (state == ST_WRITE);
   assign bus_addr  = (state == ST_WRITE) ? side_addr[1] : side_addr[0];
   assign bus_word  = word_q;
   assign bus_wdata = data_q;
   assign busy      = (state != ST_IDLE);
   assign enable    = en_q;
   assign done      = done_q;

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

   p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_ready && !cfg_we) |=> (bus_rd && $stable(bus_addr)));

   p_wdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_ready && bus_word && !ctrl_wr) |=> (bus_wdata == $past(bus_rdata)));

   p_done_clears_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !enable);

   p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !enable) |=> !busy);
endmodule

// File: tb/blkdma_seq_tb.sv
module blkdma_seq_tb;
   import blkdma_pkg::*;

   typedef struct packed {
      logic        is_wr;
      logic [23:0] addr;
      logic [15:0] data;
   } bus_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [23:0] cfg_wdata = '0;
   logic        req = 1'b0;
   logic [23:0] bus_addr;
   logic        bus_rd, bus_wr, bus_word;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        bus_ready = 1'b0;
   logic        busy, enable, done;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   bus_item_t exp_q[$];

   // bench-side model of the programmed transfer
   logic [23:0] m_src, m_dst, m_src0, m_dst0;
   int          m_size;
   logic        m_word, m_area_dst;
   int          m_smode, m_dmode;

   always #2.5 clk = ~clk;

   blkdma_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req(req), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy),
      .enable(enable), .done(done)
   );

   function automatic logic [15:0] mem_val(input logic [23:0] a);
      return a[15:0] ^ 16'hA5C3 ^ {a[23:16], a[23:16]};
   endfunction

   function automatic logic [23:0] next_a(input logic [23:0] a, input int mode, input logic w);
      logic [23:0] st;
      st = w ? 24'd2 : 24'd1;
      if (mode == 1) return a + st;
      if (mode == 2) return a - st;
      return a;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<100000", cycles);
         finish_run();
      end
   end

   // bus model and scoreboard monitor
   int wcnt = 0;
   int wtarget = 0;
   always @(negedge clk) begin
      bus_ready = 1'b0;
      if (rst_n && (bus_rd || bus_wr)) begin
         chk(!(bus_rd && bus_wr), "R7 strobes exclusive", {46'd0, bus_rd, bus_wr}, 48'd0);
         if (wcnt >= wtarget) begin
            bus_item_t e;
            bus_ready = 1'b1;
            bus_rdata = mem_val(bus_addr);
            wcnt = 0;
            wtarget = (wtarget + 1) % 3;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected bus cycle", {23'd0, bus_wr, bus_addr}, 48'd0);
            end else begin
               e = exp_q.pop_front();
               chk(e.is_wr == bus_wr, "R2 cycle kind", {47'd0, bus_wr}, {47'd0, e.is_wr});
               chk(e.addr == bus_addr, e.is_wr ? "R4 write address" : "R3 read address",
                   {24'd0, bus_addr}, {24'd0, e.addr});
               if (e.is_wr)
                  chk(e.data == bus_wdata, "R8 write data", {32'd0, bus_wdata}, {32'd0, e.data});
            end
         end else begin
            wcnt++;
         end
      end
   end

   task automatic cfg_write(input logic [2:0] sel, input logic [23:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input logic [23:0] src, input logic [23:0] dst, input int size,
                        input int blocks, input logic w, input logic area_dst,
                        input int smode, input int dmode);
      m_src = src; m_src0 = src; m_dst = dst; m_dst0 = dst;
      m_size = size; m_word = w; m_area_dst = area_dst;
      m_smode = smode; m_dmode = dmode;
      cfg_write(SEL_SRC, src);
      cfg_write(SEL_DST, dst);
      cfg_write(SEL_SIZE, {8'd0, 8'(size), 8'(size)});
      cfg_write(SEL_BLOCKS, 24'(blocks));
      cfg_write(SEL_CTRL, {17'd0, 2'(dmode), 2'(smode), area_dst, w, 1'b1});
   endtask

   // driver: push one block of expected items, request it, wait for completion
   task automatic run_block(input bit extra_req);
      for (int u = 0; u < m_size; u++) begin
         logic [15:0] d;
         d = mem_val(m_src);
         if (!m_word) d = {8'd0, d[7:0]};
         exp_q.push_back('{is_wr: 1'b0, addr: m_src, data: 16'd0});
         exp_q.push_back('{is_wr: 1'b1, addr: m_dst, data: d});
         m_src = next_a(m_src, m_smode, m_word);
         m_dst = next_a(m_dst, m_dmode, m_word);
      end
      if (m_area_dst) m_dst = m_dst0;
      else            m_src = m_src0;
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      chk(busy == 1'b1, "R2 request starts block", {47'd0, busy}, 48'd1);
      if (extra_req) begin
         repeat (3) @(negedge clk);
         req = 1'b1;
         @(negedge clk); req = 1'b0;
      end
      for (int t = 0; t < 2000 && busy; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && !busy, "R2 block fully transferred",
          {16'd0, 32'(exp_q.size())}, 48'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!bus_rd && !bus_wr && !busy && !enable && !done, "R9 reset state",
          {43'd0, bus_rd, bus_wr, busy, enable, done}, 48'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: request while disabled is ignored
      cfg_write(SEL_SRC, 24'h000100);
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      repeat (8) @(negedge clk);
      chk(!busy && !bus_rd, "R6 request ignored when disabled", {46'd0, busy, bus_rd}, 48'd0);

      // Case 1: bytes, both incrementing, destination is block area, 3x2
      setup(24'h001000, 24'h200000, 3, 2, 1'b0, 1'b1, 1, 1);
      run_block(1'b0);
      chk(!done && enable, "R5 not done after first of two blocks", {46'd0, done, enable}, 48'd1);
      run_block(1'b0);
      chk(done && !enable, "R5 done and enable cleared after last block",
          {46'd0, done, enable}, 48'd2);

      // R6: request after completion (enable now 0) is ignored
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      repeat (6) @(negedge clk);
      chk(!busy, "R6 request ignored after finish", {47'd0, busy}, 48'd0);

      // Case 2: words, source decrementing and block area, destination fixed, 2x2,
      // with an extra request in mid-block that must be ignored
      setup(24'h00F000, 24'h300010, 2, 2, 1'b1, 1'b0, 2, 0);
      chk(!done, "R5 control write clears done", {47'd0, done}, 48'd0);
      chk(bus_word, "R3 word unit selected", {47'd0, bus_word}, 48'd1);
      run_block(1'b1);
      run_block(1'b0);
      chk(done && !enable, "R5 finish after word blocks", {46'd0, done, enable}, 48'd2);

      // Case 3: bytes, source fixed, destination decrementing, single block of 4
      setup(24'h000055, 24'h400003, 4, 1, 1'b0, 1'b1, 0, 2);
      run_block(1'b0);
      chk(done && !enable, "R5 single block finish", {46'd0, done, enable}, 48'd2);

      // Case 4: words, both incrementing, source block area, 1x3 (R1 reload of addresses)
      setup(24'h000200, 24'h500000, 1, 3, 1'b1, 1'b0, 1, 1);
      run_block(1'b0);
      run_block(1'b0);
      run_block(1'b0);
      chk(done && !enable, "R1 three one-unit blocks finish", {46'd0, done, enable}, 48'd2);

      finish_run();
   end
endmodule